// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block is a small time-division switch. It carries four byte-wide streams, and each stream has 32 channel slots per frame. All four streams are presented in parallel, one slot per clock. The byte received in every slot is stored in a double-buffered data memory. For each outgoing slot, a connection memory entry chooses what to send. The entry can pick a stored byte from any stream and channel, or it can send a fixed byte taken from the entry itself. The same entry also sets the slot's output enable, whether the slot's own output is looped back into its receive path, and whether the switched byte comes with constant or variable delay.

A byte-wide processor port reaches all of this state through one 8-bit address space. Address zero holds a small control register. The upper half of the address space opens a 32-location window onto either memory, and the control register chooses which memory and which stream the window shows. A global gate controls all outputs. It is the OR of an input pin and a control-register bit, and while it is low every slot is disabled, so software can program the connection memory safely before traffic is released.

Top module: `tsi_switch`

## Requirements
- R1: `cur_slot` is 0 after reset and advances by one every clock. After 31 it wraps to 0. If `frame_start` is high in a cycle, the next slot is 0. Every return to slot 0 begins a new frame and swaps the two halves of the data memory.
- R2: Address 0x00 is a 4-bit control register. Bits [1:0] select the stream. Bit [2] selects the target, where 1 means connection memory and 0 means data memory. Bit [3] is the soft output enable. A write takes effect in the next cycle. A read returns the register zero-extended. The register is 0 after reset.
- R3: An address with bit 7 set reaches channel `p_addr[4:0]` of stream CR[1:0] in the selected target, and bits 6:5 are ignored. Addresses 0x01 to 0x7F change nothing when written and read back as 0.
- R4: A connection entry is 12 bits wide. Bit 11 selects processor byte. Bit 10 is the output enable. Bit 9 is loopback. Bit 8 selects constant delay. Bits 7:0 hold the byte. In switched mode, bits 6:5 give the source stream and bits 4:0 give the source channel. A read returns the entry exactly as written.
- R5: With bit 11 set, `tx_data` for the slot carries entry bits 7:0. `tx_data` always carries the slot's byte, whether or not the slot is enabled.
- R6: With bit 11 clear and bit 8 set, the output byte is the byte that arrived on the source stream and channel during the previous frame.
- R7: With bits 11 and 8 clear, the source is read from the current frame when the source channel is lower than the current slot. Otherwise it is read from the previous frame.
- R8: `tx_en[s]` is high only when (`out_gate` OR CR[3]) is high and entry bit 10 is set. While both gate terms are low, all enables are 0, whatever the memory holds.
- R9: When entry bit 9 is set for stream s in slot c, the byte stored for stream s channel c is that slot's own output byte, and `rx_data` is ignored.
- R10: When the target is data memory, a read returns, zero-extended, the byte of the last completed frame for stream CR[1:0] and channel `p_addr[4:0]`. A write replaces that byte. Later reads and previous-frame outputs then see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Restart at slot 0 on the next clock |
| out_gate | input | 1 | Global output gate pin |
| rx_data | input | 32 | Received bytes of the current slot, stream s in bits 8s+7:8s |
| tx_data | output | 32 | Output bytes of the current slot, same packing |
| tx_en | output | 4 | Per-stream drive enable for the current slot |
| cur_slot | output | 5 | Current channel slot |
| p_addr | input | 8 | Processor address |
| p_wr | input | 1 | Processor write strobe |
| p_wdata | input | 12 | Processor write data |
| p_rdata | output | 12 | Processor read data, combinational from the address |

## Verification
The bench targets the variable-delay boundary: sources that lie before the current slot, at it and after it. A design that compared the wrong way, or read the wrong half of the memory, would output a byte one frame stale or one frame early. It also aborts a frame partway with `frame_start` and checks that the memory halves swap at that point. If they did not, every previous-frame output would read bytes that are still being overwritten. Loopback slots are then used as sources for other slots, which exposes a design that stores `rx_data` instead of the slot's own output. Writes to the dead addresses 0x01 to 0x7F, and enable checks taken while the gate is low over random memory contents, catch decode aliasing and any leak of per-slot enables.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int STREAMS_DEF = 4;
    localparam int CHANS_DEF   = 32;
    localparam int BYTE_W_DEF  = 8;
    localparam int ADDR_W      = 8;
    // connection entry flag bits sit above the byte field
    localparam int ENTRY_FLAGS = 4;
    localparam int FLAG_CDLY   = 0;
    localparam int FLAG_LOOP   = 1;
    localparam int FLAG_OE     = 2;
    localparam int FLAG_PC     = 3;

    typedef enum logic {
        TGT_DATA = 1'b0,
        TGT_CONN = 1'b1
    } mem_tgt_e;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
#(
    parameter int CHANS = CHANS_DEF,
    localparam int CW = $clog2(CHANS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [CW-1:0] slot,
    output logic          bank
);
    localparam logic [CW-1:0] LAST = CW'(CHANS - 1);

    typedef struct packed {
        logic [CW-1:0] slot;
        logic          bank;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (frame_start || tmr_q.slot == LAST) begin
            tmr_d.slot = '0;
            tmr_d.bank = ~tmr_q.bank;
        end else begin
            tmr_d.slot = tmr_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign slot = tmr_q.slot;
    assign bank = tmr_q.bank;

    // R1
    slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start || slot == LAST) |=> (slot == '0));
    // R1
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && slot != LAST) |=> (slot == $past(slot) + 1'b1));
    // R1
    bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start || slot == LAST) |=> (bank != $past(bank)));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int STREAMS = STREAMS_DEF,
    parameter int CHANS   = CHANS_DEF,
    parameter int BYTE_W  = BYTE_W_DEF,
    localparam int SW = $clog2(STREAMS),
    localparam int CW = $clog2(CHANS)
) (
    input  logic                             clk,
    input  logic                             bank,
    input  logic [CW-1:0]                    slot,
    input  logic [STREAMS-1:0][BYTE_W-1:0]   wr_bytes,
    input  logic [STREAMS-1:0][SW-1:0]       rd_strm,
    input  logic [STREAMS-1:0][CW-1:0]       rd_chan,
    input  logic [STREAMS-1:0]               rd_cur,
    output logic [STREAMS-1:0][BYTE_W-1:0]   rd_bytes,
    input  logic                             p_we,
    input  logic [SW-1:0]                    p_strm,
    input  logic [CW-1:0]                    p_chan,
    input  logic [BYTE_W-1:0]                p_wdata,
    output logic [BYTE_W-1:0]                p_rdata
);
    // half [bank] fills with the current frame, half [~bank] holds the last one
    logic [BYTE_W-1:0] mem_d [2][STREAMS][CHANS];
    logic [BYTE_W-1:0] mem_q [2][STREAMS][CHANS];

    always_comb begin
        mem_d = mem_q;
        for (int s = 0; s < STREAMS; s++) begin
            mem_d[bank][s][slot] = wr_bytes[s];
        end
        if (p_we) mem_d[~bank][p_strm][p_chan] = p_wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar g = 0; g < STREAMS; g++) begin : g_rd
        assign rd_bytes[g] = mem_q[rd_cur[g] ? bank : ~bank][rd_strm[g]][rd_chan[g]];
    end

    assign p_rdata = mem_q[~bank][p_strm][p_chan];
endmodule

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
    import tsi_pkg::*;
#(
    parameter int STREAMS = STREAMS_DEF,
    parameter int CHANS   = CHANS_DEF,
    parameter int BYTE_W  = BYTE_W_DEF,
    localparam int SW  = $clog2(STREAMS),
    localparam int CW  = $clog2(CHANS),
    localparam int EW  = BYTE_W + ENTRY_FLAGS,
    localparam int CRW = SW + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           p_addr,
    input  logic                        p_wr,
    input  logic [EW-1:0]               p_wdata,
    output logic [EW-1:0]               p_rdata,
    input  logic [CW-1:0]               slot,
    output logic [STREAMS-1:0][EW-1:0]  cm_cur,
    output logic                        soft_en,
    output logic                        dm_we,
    output logic [SW-1:0]               dm_strm,
    output logic [CW-1:0]               dm_chan,
    input  logic [BYTE_W-1:0]           dm_rdata
);
    logic [CRW-1:0] cr_d, cr_q;
    logic [EW-1:0]  cm_d [STREAMS][CHANS];
    logic [EW-1:0]  cm_q [STREAMS][CHANS];

    logic      hit_cr, hit_mem;
    mem_tgt_e  tgt;
    logic [SW-1:0] sel_strm;
    logic [CW-1:0] sel_chan;

    assign hit_cr   = (p_addr == '0);
    assign hit_mem  = p_addr[ADDR_W-1];
    assign tgt      = mem_tgt_e'(cr_q[SW]);
    assign sel_strm = cr_q[SW-1:0];
    assign sel_chan = p_addr[CW-1:0];

    always_comb begin
        cr_d = cr_q;
        cm_d = cm_q;
        if (p_wr && hit_cr) cr_d = p_wdata[CRW-1:0];
        if (p_wr && hit_mem && tgt == TGT_CONN) cm_d[sel_strm][sel_chan] = p_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    always_ff @(posedge clk) begin
        cm_q <= cm_d;
    end

    always_comb begin
        p_rdata = '0;
        if (hit_cr) begin
            p_rdata = EW'(cr_q);
        end else if (hit_mem) begin
            p_rdata = (tgt == TGT_CONN) ? cm_q[sel_strm][sel_chan] : EW'(dm_rdata);
        end
    end

    for (genvar g = 0; g < STREAMS; g++) begin : g_cur
        assign cm_cur[g] = cm_q[g][slot];
    end

    assign soft_en = cr_q[SW+1];
    assign dm_we   = p_wr && hit_mem && (tgt == TGT_DATA);
    assign dm_strm = sel_strm;
    assign dm_chan = sel_chan;

    // R2
    cr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wr && p_addr == '0) |=> (cr_q == $past(p_wdata[CRW-1:0])));
    // R3
    cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_wr && p_addr == '0) |=> $stable(cr_q));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int STREAMS = STREAMS_DEF,
    parameter int CHANS   = CHANS_DEF,
    parameter int BYTE_W  = BYTE_W_DEF,
    localparam int SW = $clog2(STREAMS),
    localparam int CW = $clog2(CHANS),
    localparam int EW = BYTE_W + ENTRY_FLAGS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        out_gate,
    input  logic [STREAMS*BYTE_W-1:0]   rx_data,
    output logic [STREAMS*BYTE_W-1:0]   tx_data,
    output logic [STREAMS-1:0]          tx_en,
    output logic [CW-1:0]               cur_slot,
    input  logic [ADDR_W-1:0]           p_addr,
    input  logic                        p_wr,
    input  logic [EW-1:0]               p_wdata,
    output logic [EW-1:0]               p_rdata
);
    logic [CW-1:0]                    slot;
    logic                             bank;
    logic [STREAMS-1:0][EW-1:0]       cm_cur;
    logic                             soft_en;
    logic                             dm_we;
    logic [SW-1:0]                    dm_strm;
    logic [CW-1:0]                    dm_chan;
    logic [BYTE_W-1:0]                dm_rdata;
    logic [STREAMS-1:0][BYTE_W-1:0]   wr_bytes;
    logic [STREAMS-1:0][SW-1:0]       rd_strm;
    logic [STREAMS-1:0][CW-1:0]       rd_chan;
    logic [STREAMS-1:0]               rd_cur;
    logic [STREAMS-1:0][BYTE_W-1:0]   rd_bytes;
    logic [STREAMS-1:0][BYTE_W-1:0]   out_byte;
    logic                             gate_on;

    tsi_frame_timer #(.CHANS(CHANS)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .slot(slot), .bank(bank)
    );

    tsi_ctrl #(.STREAMS(STREAMS), .CHANS(CHANS), .BYTE_W(BYTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .p_addr(p_addr), .p_wr(p_wr),
        .p_wdata(p_wdata), .p_rdata(p_rdata), .slot(slot), .cm_cur(cm_cur),
        .soft_en(soft_en), .dm_we(dm_we), .dm_strm(dm_strm),
        .dm_chan(dm_chan), .dm_rdata(dm_rdata)
    );

    tsi_data_mem #(.STREAMS(STREAMS), .CHANS(CHANS), .BYTE_W(BYTE_W)) u_dmem (
        .clk(clk), .bank(bank), .slot(slot), .wr_bytes(wr_bytes),
        .rd_strm(rd_strm), .rd_chan(rd_chan), .rd_cur(rd_cur),
        .rd_bytes(rd_bytes), .p_we(dm_we), .p_strm(dm_strm),
        .p_chan(dm_chan), .p_wdata(p_wdata[BYTE_W-1:0]), .p_rdata(dm_rdata)
    );

    assign gate_on  = out_gate || soft_en;
    assign cur_slot = slot;

    for (genvar g = 0; g < STREAMS; g++) begin : g_strm
        logic [EW-1:0] entry;
        assign entry      = cm_cur[g];
        assign rd_strm[g] = entry[CW+SW-1:CW];
        assign rd_chan[g] = entry[CW-1:0];
        // variable delay takes this frame's byte only for sources already passed
        assign rd_cur[g]  = !entry[BYTE_W+FLAG_CDLY] && (entry[CW-1:0] < slot);
        assign out_byte[g] = entry[BYTE_W+FLAG_PC] ? entry[BYTE_W-1:0] : rd_bytes[g];
        assign wr_bytes[g] = entry[BYTE_W+FLAG_LOOP] ? out_byte[g]
                                                     : rx_data[g*BYTE_W +: BYTE_W];
        assign tx_data[g*BYTE_W +: BYTE_W] = out_byte[g];
        assign tx_en[g] = gate_on && entry[BYTE_W+FLAG_OE];
    end

    // R8
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_gate || soft_en) |-> (tx_en == '0));
endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        frame_start;
    logic        out_gate;
    logic [31:0] rx_data;
    logic [31:0] tx_data;
    logic [3:0]  tx_en;
    logic [4:0]  cur_slot;
    logic [7:0]  p_addr;
    logic        p_wr;
    logic [11:0] p_wdata;
    logic [11:0] p_rdata;

    tsi_switch uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .out_gate(out_gate),
        .rx_data(rx_data), .tx_data(tx_data), .tx_en(tx_en), .cur_slot(cur_slot),
        .p_addr(p_addr), .p_wr(p_wr), .p_wdata(p_wdata), .p_rdata(p_rdata)
    );

    // reference state built from the requirements
    logic [7:0]  dm_m [2][4][32];
    bit          dv_m [2][4][32];
    bit          lb_m [2][4][32];
    logic [11:0] cm_m [4][32];
    bit          cv_m [4][32];
    logic [3:0]  cr_m;
    int          slot_m;
    bit          bank_m;
    bit          gate_m;
    int          n_chk;
    int          n_fail;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] rand_entry();
        logic [11:0] e;
        e = 12'($urandom);
        e[11] = ($urandom_range(0, 4) == 0);
        e[9]  = ($urandom_range(0, 3) == 0);
        return e;
    endfunction

    // one clock: drive at a falling edge, check, then advance the reference
    task automatic run_cycle(input bit fs, input bit wr, input logic [7:0] addr,
                             input logic [11:0] wd);
        logic [7:0]  exp_b [4];
        bit          exp_v [4];
        bit          exp_l [4];
        logic [7:0]  rx_b  [4];
        logic [11:0] e;
        string       tag;
        frame_start = fs;
        p_wr        = wr;
        p_addr      = addr;
        p_wdata     = wd;
        out_gate    = gate_m;
        for (int s = 0; s < 4; s++) begin
            rx_b[s] = 8'($urandom);
            rx_data[s*8 +: 8] = rx_b[s];
        end
        #1;
        chk("R1", "cur_slot", int'(cur_slot), slot_m);
        for (int s = 0; s < 4; s++) begin
            e = cm_m[s][slot_m];
            exp_v[s] = 1'b0;
            exp_l[s] = 1'b0;
            exp_b[s] = 8'h00;
            if (cv_m[s][slot_m]) begin
                if (e[11]) begin
                    exp_b[s] = e[7:0];
                    exp_v[s] = 1'b1;
                    tag = "R5";
                end else begin
                    bit bk;
                    int ss;
                    int sc;
                    ss = int'(e[6:5]);
                    sc = int'(e[4:0]);
                    bk = (!e[8] && sc < slot_m) ? bank_m : !bank_m;
                    exp_b[s] = dm_m[bk][ss][sc];
                    exp_v[s] = dv_m[bk][ss][sc];
                    tag = lb_m[bk][ss][sc] ? "R9" : (e[8] ? "R6" : "R7");
                end
                if (exp_v[s]) chk(tag, $sformatf("tx_data[%0d]", s), int'(tx_data[s*8 +: 8]), int'(exp_b[s]));
            end
            if (cv_m[s][slot_m] || !(gate_m || cr_m[3]))
                chk("R8", $sformatf("tx_en[%0d]", s), int'(tx_en[s]),
                    int'((gate_m || cr_m[3]) && cv_m[s][slot_m] && e[10]));
        end
        // processor read port
        if (addr == 8'h00) begin
            chk("R2", "ctrl readback", int'(p_rdata), int'(cr_m));
        end else if (addr[7]) begin
            int c;
            int st;
            c  = int'(addr[4:0]);
            st = int'(cr_m[1:0]);
            if (cr_m[2]) begin
                if (cv_m[st][c]) chk("R4", "conn readback", int'(p_rdata), int'(cm_m[st][c]));
            end else begin
                if (dv_m[!bank_m][st][c])
                    chk("R10", "data readback", int'(p_rdata), int'(dm_m[!bank_m][st][c]));
            end
        end else begin
            chk("R3", "dead address read", int'(p_rdata), 0);
        end
        // reference update for the coming rising edge
        for (int s = 0; s < 4; s++) begin
            e = cm_m[s][slot_m];
            if (!cv_m[s][slot_m]) begin
                dv_m[bank_m][s][slot_m] = 1'b0;
                lb_m[bank_m][s][slot_m] = 1'b0;
            end else if (e[9]) begin
                dm_m[bank_m][s][slot_m] = exp_b[s];
                dv_m[bank_m][s][slot_m] = exp_v[s];
                lb_m[bank_m][s][slot_m] = 1'b1;
            end else begin
                dm_m[bank_m][s][slot_m] = rx_b[s];
                dv_m[bank_m][s][slot_m] = 1'b1;
                lb_m[bank_m][s][slot_m] = 1'b0;
            end
        end
        if (wr) begin
            if (addr == 8'h00) begin
                cr_m = wd[3:0];
            end else if (addr[7]) begin
                if (cr_m[2]) begin
                    cm_m[cr_m[1:0]][addr[4:0]] = wd;
                    cv_m[cr_m[1:0]][addr[4:0]] = 1'b1;
                end else begin
                    dm_m[!bank_m][cr_m[1:0]][addr[4:0]] = wd[7:0];
                    dv_m[!bank_m][cr_m[1:0]][addr[4:0]] = 1'b1;
                    lb_m[!bank_m][cr_m[1:0]][addr[4:0]] = 1'b0;
                end
            end
        end
        if (fs || slot_m == 31) begin
            slot_m = 0;
            bank_m = !bank_m;
        end else begin
            slot_m = slot_m + 1;
        end
        @(negedge clk);
    endtask

    task automatic write_entry(input int st, input int ch, input logic [11:0] ent);
        run_cycle(1'b0, 1'b1, 8'h00, {8'h00, cr_m[3], 1'b1, 2'(st)});
        run_cycle(1'b0, 1'b1, {3'b100, 5'(ch)}, ent);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        n_chk = 0;
        n_fail = 0;
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 32; c++) begin
                    dv_m[b][s][c] = 1'b0;
                    lb_m[b][s][c] = 1'b0;
                end
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 32; c++) cv_m[s][c] = 1'b0;
        cr_m = 4'h0;
        slot_m = 0;
        bank_m = 1'b0;
        gate_m = 1'b0;
        rst_n = 1'b0;
        frame_start = 1'b0;
        out_gate = 1'b0;
        p_wr = 1'b0;
        p_addr = 8'h00;
        p_wdata = 12'h000;
        rx_data = 32'h0;
        repeat (3) @(negedge clk);
        // reset state
        chk("R1", "slot in reset", int'(cur_slot), 0);
        chk("R8", "enables in reset", int'(tx_en), 0);
        chk("R2", "ctrl in reset", int'(p_rdata), 0);
        rst_n = 1'b1;

        // program every entry with the gate low
        for (int st = 0; st < 4; st++) begin
            run_cycle(1'b0, 1'b1, 8'h00, {8'h00, 4'b0100 | 4'(st)});
            for (int c = 0; c < 32; c++)
                run_cycle(1'b0, 1'b1, {3'b100, 5'(c)}, rand_entry());
        end
        // directed entries: delay boundary, pass-through, loopback chain
        write_entry(0, 5,  12'h405);  // variable, source is own slot
        write_entry(1, 6,  12'h440);  // variable, source stream 2 slot 0
        write_entry(0, 0,  12'h41F);  // variable, source later in frame
        write_entry(2, 31, 12'hCA5);  // processor byte
        write_entry(3, 0,  12'hE3C);  // processor byte looped back
        write_entry(3, 9,  12'h560);  // constant, reads looped slot
        // dead address writes leave everything intact
        run_cycle(1'b0, 1'b1, 8'h40, 12'hFFF);
        run_cycle(1'b0, 1'b0, 8'h40, 12'h000);
        run_cycle(1'b0, 1'b1, 8'h1F, 12'hFFF);
        run_cycle(1'b0, 1'b0, 8'h00, 12'h000);
        // two frames still gated off
        for (int i = 0; i < 64; i++) run_cycle(1'b0, 1'b0, 8'h00, 12'h000);
        // open the gate, three quiet frames
        gate_m = 1'b1;
        for (int i = 0; i < 96; i++) run_cycle(1'b0, 1'b0, 8'h00, 12'h000);
        // abort a frame partway
        for (int i = 0; i < 10; i++) run_cycle(1'b0, 1'b0, 8'h00, 12'h000);
        run_cycle(1'b1, 1'b0, 8'h00, 12'h000);
        for (int i = 0; i < 70; i++) run_cycle(1'b0, 1'b0, 8'h00, 12'h000);
        // soft enable with the pin low
        gate_m = 1'b0;
        run_cycle(1'b0, 1'b1, 8'h00, 12'h008);
        for (int i = 0; i < 40; i++) run_cycle(1'b0, 1'b0, 8'h00, 12'h000);
        gate_m = 1'b1;
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int  r;
            bit  fs;
            r  = $urandom_range(0, 15);
            fs = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 299) == 0) gate_m = !gate_m;
            if (r == 0)
                run_cycle(fs, 1'b1, 8'h00,
                          {8'h00, ($urandom_range(0, 2) == 0), 1'($urandom), 2'($urandom)});
            else if (r <= 3)
                run_cycle(fs, 1'b1, {1'b1, 2'($urandom), 5'($urandom)},
                          (r == 1) ? rand_entry() : 12'($urandom));
            else if (r == 4)
                run_cycle(fs, 1'b1, {1'b0, 7'($urandom_range(1, 127))}, 12'($urandom));
            else if (r <= 9)
                run_cycle(fs, 1'b0, {1'b1, 2'($urandom), 5'($urandom)}, 12'h000);
            else
                run_cycle(fs, 1'b0, 8'($urandom), 12'h000);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule